// File: doc/BRIEF.md
# Self-Routing Omega Network

This block moves up to PORTS packets per cycle from PORTS sources to PORTS sinks through log2(PORTS) columns of two-by-two switching elements, PORTS/2 elements per column. A fixed wiring that rotates each line index left by one bit feeds every column. No central scheduler exists: every element looks at one bit of each arriving packet's destination tag and steers the packet to its upper or lower output. Sources offer a valid flag, a destination number and a payload on each input; sinks see a valid flag, the payload and the number of the source that sent it on each output.

The stream edge has no ready signal and no back-pressure. A source offers a packet by raising its valid bit for one cycle, and the network either delivers it or drops it. The only feedback is the per-source reject bit, which tells a source that its packet lost a conflict inside an element and may be offered again. Sinks must accept every valid output in the cycle it appears. The parameter STAGE_REG picks a purely combinational network (0) or one register after every column (1).

Top module: `omega_net`

## Requirements
- R1: A packet that is not rejected appears on the output whose index equals its destination tag, with its payload on out_data and its input index on out_src.
- R2: Conflict-free patterns pass whole: the identity mapping (input i to output i) and the cyclic shift (input i to output (i+1) mod PORTS) deliver every packet and raise no reject.
- R3: Column s (s = 0 first) wires line p to position ((p<<1)|(p>>(log2(PORTS)-1))) mod PORTS; element k takes positions 2k (upper) and 2k+1 (lower) and reads destination bit log2(PORTS)-1-s, where 0 selects the upper output and 1 the lower; when two valid packets in one element select the same output, one is passed and the other is dropped with the reject bit of its source raised.
- R4: Each element holds a one-bit priority: 0 favours its upper input, 1 its lower input; the priority flips on the clock edge after every conflict, so the other input wins the next conflict in that element.
- R5: An input whose valid bit is 0 produces no output, no reject, and leaves every element priority unchanged.
- R6: With STAGE_REG = 0, outputs and rejects appear in the same cycle the inputs are offered.
- R7: With STAGE_REG = 1, a packet appears on the outputs exactly log2(PORTS) clock edges after it is offered, and a loss in column s raises its reject bit s edges after it was offered.
- R8: Reset (rst_n low) sets every element priority to 0 and empties all column registers, so the outputs carry no valid packet.
- R9: With STAGE_REG = 0, in every cycle the number of valid inputs equals the number of valid outputs plus the number of reject bits raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | PORTS | Packet offered on each input |
| in_dest | input | PORTS x log2(PORTS) | Destination number per input |
| in_data | input | PORTS x DATA_W | Payload per input |
| out_valid | output | PORTS | Packet present on each output |
| out_data | output | PORTS x DATA_W | Payload per output |
| out_src | output | PORTS x log2(PORTS) | Input index of the packet on each output |
| reject | output | PORTS | Packet of this source was dropped in this cycle |

## Verification
The bench builds two copies with eight ports and eight-bit payloads: one with STAGE_REG = 0 and one with STAGE_REG = 1. Eight ports give three columns, so conflicts can be placed deliberately in the first and in the middle column and the priority flip of a single element can be watched over several consecutive conflicts. The registered copy, fed from its own inputs, makes the three-edge latency and the staggered timing of a middle-column reject observable without disturbing the priorities of the combinational copy.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Position a line takes after the inter-column wiring: index rotated left by one bit.
  function automatic int unsigned shuffle_pos(input int unsigned pos, input int unsigned lg);
    int unsigned mask;
    mask = (32'd1 << lg) - 32'd1;
    return ((pos << 1) | (pos >> (lg - 1))) & mask;
  endfunction

endpackage

// File: rtl/omega_elem.sv
module omega_elem #(
  parameter int PKT_W = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            in_v,
  input  logic [1:0]            in_bit,
  input  logic [1:0][PKT_W-1:0] in_pkt,
  output logic [1:0]            out_v,
  output logic [1:0][PKT_W-1:0] out_pkt,
  output logic [1:0]            rej
);

  logic favor_lo;
  logic clash;
  logic want_up;
  logic want_lo;
  logic take_lo;

  always_comb begin
    clash  = in_v[0] && in_v[1] && (in_bit[0] == in_bit[1]);
    rej[0] = clash && favor_lo;
    rej[1] = clash && !favor_lo;
    for (int o = 0; o < 2; o++) begin
      want_up    = in_v[0] && (in_bit[0] == 1'(o));
      want_lo    = in_v[1] && (in_bit[1] == 1'(o));
      take_lo    = want_lo && (!want_up || favor_lo);
      out_v[o]   = want_up || want_lo;
      out_pkt[o] = take_lo ? in_pkt[1] : in_pkt[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      favor_lo <= 1'b0;
    else if (clash)
      favor_lo <= !favor_lo;
  end

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int PORTS      = 8,
  parameter int LOG2       = 3,
  parameter int DATA_W     = 8,
  parameter int PKT_W      = 14,
  parameter int STAGE      = 0,
  parameter bit REGISTERED = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PORTS-1:0]          in_v,
  input  logic [PORTS-1:0][PKT_W-1:0] in_pkt,
  output logic [PORTS-1:0]          out_v,
  output logic [PORTS-1:0][PKT_W-1:0] out_pkt,
  output logic [PORTS-1:0]          rej_src
);

  localparam int ELEMS   = PORTS / 2;
  localparam int TAG_BIT = DATA_W + LOG2 - 1 - STAGE;
  localparam int SRC_LO  = DATA_W + LOG2;

  logic [PORTS-1:0]            sh_v;
  logic [PORTS-1:0][PKT_W-1:0] sh_pkt;
  logic [PORTS-1:0]            sw_v;
  logic [PORTS-1:0][PKT_W-1:0] sw_pkt;
  logic [PORTS-1:0]            rej_pos;

  // Inter-column wiring
  for (genvar p = 0; p < PORTS; p++) begin : g_shuffle
    localparam int DST = int'(omega_pkg::shuffle_pos(p, LOG2));
    assign sh_v[DST]   = in_v[p];
    assign sh_pkt[DST] = in_pkt[p];
  end

  // Column of two-by-two elements
  for (genvar k = 0; k < ELEMS; k++) begin : g_elem
    omega_elem #(.PKT_W(PKT_W)) u_elem (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_v    (sh_v[2*k +: 2]),
      .in_bit  ({sh_pkt[2*k+1][TAG_BIT], sh_pkt[2*k][TAG_BIT]}),
      .in_pkt  (sh_pkt[2*k +: 2]),
      .out_v   (sw_v[2*k +: 2]),
      .out_pkt (sw_pkt[2*k +: 2]),
      .rej     (rej_pos[2*k +: 2])
    );
  end

  // Map a dropped packet back to the input it came from
  always_comb begin
    rej_src = '0;
    for (int p = 0; p < PORTS; p++) begin
      if (rej_pos[p])
        rej_src[sh_pkt[p][SRC_LO +: LOG2]] = 1'b1;
    end
  end

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        out_v <= '0;
      else
        out_v <= sw_v;
    end
    always_ff @(posedge clk) begin
      out_pkt <= sw_pkt;
    end
  end else begin : g_wire
    assign out_v   = sw_v;
    assign out_pkt = sw_pkt;
  end

endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int PORTS     = 8,
  parameter int DATA_W    = 8,
  parameter bit STAGE_REG = 1'b0
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [PORTS-1:0]                      in_valid,
  input  logic [PORTS-1:0][$clog2(PORTS)-1:0]   in_dest,
  input  logic [PORTS-1:0][DATA_W-1:0]          in_data,
  output logic [PORTS-1:0]                      out_valid,
  output logic [PORTS-1:0][DATA_W-1:0]          out_data,
  output logic [PORTS-1:0][$clog2(PORTS)-1:0]   out_src,
  output logic [PORTS-1:0]                      reject
);

  localparam int LOG2  = $clog2(PORTS);
  localparam int PKT_W = 2 * LOG2 + DATA_W;

  // Packet layout, high to low: source index, destination tag, payload
  logic [LOG2:0][PORTS-1:0]            lvl_v;
  logic [LOG2:0][PORTS-1:0][PKT_W-1:0] lvl_pkt;
  logic [LOG2-1:0][PORTS-1:0]          stg_rej;
  logic [PORTS-1:0][LOG2-1:0]          arrived_tag;

  for (genvar i = 0; i < PORTS; i++) begin : g_inject
    assign lvl_v[0][i]   = in_valid[i];
    assign lvl_pkt[0][i] = {LOG2'(i), in_dest[i], in_data[i]};
  end

  for (genvar s = 0; s < LOG2; s++) begin : g_stage
    omega_stage #(
      .PORTS      (PORTS),
      .LOG2       (LOG2),
      .DATA_W     (DATA_W),
      .PKT_W      (PKT_W),
      .STAGE      (s),
      .REGISTERED (STAGE_REG)
    ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_v    (lvl_v[s]),
      .in_pkt  (lvl_pkt[s]),
      .out_v   (lvl_v[s+1]),
      .out_pkt (lvl_pkt[s+1]),
      .rej_src (stg_rej[s])
    );
  end

  always_comb begin
    reject = '0;
    for (int s = 0; s < LOG2; s++)
      reject = reject | stg_rej[s];
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_eject
    assign out_data[p]    = lvl_pkt[LOG2][p][DATA_W-1:0];
    assign arrived_tag[p] = lvl_pkt[LOG2][p][DATA_W +: LOG2];
    assign out_src[p]     = lvl_pkt[LOG2][p][DATA_W+LOG2 +: LOG2];
  end
  assign out_valid = lvl_v[LOG2];

endmodule

// File: rtl/omega_net_checker.sv
module omega_net_checker #(
  parameter int PORTS     = 8,
  parameter int DATA_W    = 8,
  parameter bit STAGE_REG = 1'b0
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [PORTS-1:0]                  in_valid,
  input logic [PORTS-1:0]                  out_valid,
  input logic [PORTS-1:0][$clog2(PORTS)-1:0] out_src,
  input logic [PORTS-1:0][$clog2(PORTS)-1:0] arrived_tag,
  input logic [PORTS-1:0]                  reject,
  input logic [PORTS-1:0][DATA_W-1:0]      out_data
);

  localparam int LOG2  = $clog2(PORTS);
  localparam int CNT_W = $clog2(LOG2 + 1) + 1;

  logic [PORTS-1:0] seen_src;
  logic             tag_bad;
  logic             deliv_bad;
  logic [CNT_W-1:0] since_rst;

  always_comb begin
    seen_src  = '0;
    tag_bad   = 1'b0;
    deliv_bad = 1'b0;
    for (int p = 0; p < PORTS; p++) begin
      if (out_valid[p]) begin
        seen_src[out_src[p]] = 1'b1;
        if (int'(arrived_tag[p]) != p)
          tag_bad = 1'b1;
        if (!in_valid[out_src[p]] || reject[out_src[p]])
          deliv_bad = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      since_rst <= '0;
    else if (since_rst < CNT_W'(LOG2))
      since_rst <= since_rst + 1'b1;
  end

  // Each output carries only packets addressed to it
  assert_tag_matches_output_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_bad);

  // No source appears on two outputs at once
  assert_source_unique_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen_src) == $countones(out_valid));

  if (STAGE_REG) begin : g_pipe_chk
    assert_empty_after_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < CNT_W'(LOG2)) |-> (out_valid == '0));
  end else begin : g_comb_chk
    assert_conserve_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(in_valid) == $countones(out_valid) + $countones(reject));
    assert_reject_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reject & ~in_valid) == '0);
    assert_delivered_was_offered_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !deliv_bad);
  end

endmodule

bind omega_net omega_net_checker #(
  .PORTS     (PORTS),
  .DATA_W    (DATA_W),
  .STAGE_REG (STAGE_REG)
) u_omega_net_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .out_src     (out_src),
  .arrived_tag (arrived_tag),
  .reject      (reject),
  .out_data    (out_data)
);

// File: tb/tb_omega_net.sv
module tb_omega_net;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [7:0]      c_valid, c_ov, c_rej;
  logic [7:0][2:0] c_dest, c_os;
  logic [7:0][7:0] c_data, c_od;
  logic [7:0]      p_valid, p_ov, p_rej;
  logic [7:0][2:0] p_dest, p_os;
  logic [7:0][7:0] p_data, p_od;

  int n_chk  = 0;
  int n_fail = 0;

  omega_net #(.PORTS(8), .DATA_W(8), .STAGE_REG(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(c_valid), .in_dest(c_dest), .in_data(c_data),
    .out_valid(c_ov), .out_data(c_od), .out_src(c_os), .reject(c_rej));

  omega_net #(.PORTS(8), .DATA_W(8), .STAGE_REG(1'b1)) dut_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(p_valid), .in_dest(p_dest), .in_data(p_data),
    .out_valid(p_ov), .out_data(p_od), .out_src(p_os), .reject(p_rej));

  // {valid[8], dest[8x3], exp out_valid[8], exp reject[8], exp src per output[8x3]}
  localparam logic [71:0] VEC [10] = '{
    {8'hFF, 3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0, 8'hFF, 8'h00, 3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0},
    {8'hFF, 3'd0,3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1, 8'hFF, 8'h00, 3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0,3'd7},
    {8'h11, 3'd0,3'd0,3'd0,3'd5,3'd0,3'd0,3'd0,3'd5, 8'h20, 8'h10, 24'd0},
    {8'h11, 3'd0,3'd0,3'd0,3'd5,3'd0,3'd0,3'd0,3'd5, 8'h20, 8'h01, 3'd0,3'd0,3'd4,3'd0,3'd0,3'd0,3'd0,3'd0},
    {8'h11, 3'd0,3'd0,3'd0,3'd5,3'd0,3'd0,3'd0,3'd5, 8'h20, 8'h10, 24'd0},
    {8'h05, 3'd0,3'd0,3'd0,3'd0,3'd0,3'd3,3'd0,3'd2, 8'h04, 8'h04, 24'd0},
    {8'h01, 3'd0,3'd0,3'd0,3'd0,3'd0,3'd3,3'd0,3'd2, 8'h04, 8'h00, 24'd0},
    {8'h05, 3'd0,3'd0,3'd0,3'd0,3'd0,3'd3,3'd0,3'd2, 8'h08, 8'h01, 3'd0,3'd0,3'd0,3'd0,3'd2,3'd0,3'd0,3'd0},
    {8'h40, 3'd0,3'd1,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0, 8'h02, 8'h00, 3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd6,3'd0},
    {8'h00, 24'd0, 8'h00, 8'h00, 24'd0}
  };

  function automatic string tag_of(input int k);
    case (k)
      0:       return "R6";
      1:       return "R2";
      2, 3, 4: return "R4";
      5:       return "R3";
      6, 9:    return "R5";
      7:       return "R4";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n   = 1'b0;
    c_valid = '0; c_dest = '0; c_data = '0;
    p_valid = '0; p_dest = '0; p_data = '0;
    repeat (3) @(negedge clk);
    #4;
    check("R8", "pipe out_valid in reset", 32'(p_ov), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // Vector table on the combinational copy; sampled in the drive cycle (R6)
    for (int k = 0; k < 10; k++) begin
      logic [71:0] v;
      logic [7:0][2:0] exp_src;
      v = VEC[k];
      @(negedge clk);
      c_valid = v[71:64];
      c_dest  = v[63:40];
      exp_src = v[23:0];
      for (int i = 0; i < 8; i++) c_data[i] = {4'(k), 1'b0, 3'(i)};
      #4;
      check(tag_of(k), $sformatf("vec %0d out_valid", k), 32'(c_ov), 32'(v[39:32]));
      check("R3", $sformatf("vec %0d reject", k), 32'(c_rej), 32'(v[31:24]));
      check("R9", $sformatf("vec %0d conservation", k),
            $countones(c_ov) + $countones(c_rej), $countones(c_valid));
      for (int p = 0; p < 8; p++) begin
        if (v[32 + p])
          check("R1", $sformatf("vec %0d out %0d src/data", k, p),
                {21'd0, c_os[p], c_od[p]}, {21'd0, exp_src[p], 4'(k), 1'b0, exp_src[p]});
      end
    end
    @(negedge clk);
    c_valid = '0;

    // R8: reset returns priorities to upper; without it source 4 would win here
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    c_valid = 8'h11; c_dest = '0; c_dest[0] = 3'd5; c_dest[4] = 3'd5;
    #4;
    check("R8", "priority after reset: reject", 32'(c_rej), 32'h10);
    check("R8", "priority after reset: src", 32'(c_os[5]), 32'd0);
    @(negedge clk);
    c_valid = '0;

    // R7: latency of the registered copy
    @(negedge clk);
    p_valid = 8'hFF;
    for (int i = 0; i < 8; i++) begin
      p_dest[i] = 3'(i);
      p_data[i] = {4'hC, 1'b0, 3'(i)};
    end
    #4;
    check("R7", "pipe out before edge", 32'(p_ov), 32'h0);
    @(negedge clk);
    p_valid = '0;
    #4;
    check("R7", "pipe out after 1 edge", 32'(p_ov), 32'h0);
    @(negedge clk);
    #4;
    check("R7", "pipe out after 2 edges", 32'(p_ov), 32'h0);
    @(negedge clk);
    #4;
    check("R7", "pipe out after 3 edges", 32'(p_ov), 32'hFF);
    for (int p = 0; p < 8; p++)
      check("R7", $sformatf("pipe out %0d src/data", p), {21'd0, p_os[p], p_od[p]},
            {21'd0, 3'(p), 4'hC, 1'b0, 3'(p)});
    @(negedge clk);
    #4;
    check("R7", "pipe out after 4 edges", 32'(p_ov), 32'h0);

    // R7: middle-column loss reported one edge after the offer
    @(negedge clk);
    p_valid = 8'h05; p_dest = '0; p_dest[0] = 3'd2; p_dest[2] = 3'd3;
    #4;
    check("R7", "mid conflict reject at offer", 32'(p_rej), 32'h0);
    @(negedge clk);
    p_valid = '0;
    #4;
    check("R7", "mid conflict reject one edge later", 32'(p_rej), 32'h04);
    @(negedge clk);
    #4;
    check("R7", "mid conflict reject cleared", 32'(p_rej), 32'h0);
    check("R7", "mid conflict out before arrival", 32'(p_ov), 32'h0);
    @(negedge clk);
    #4;
    check("R7", "mid conflict winner delivered", {24'd0, p_ov}, 32'h04);
    check("R7", "mid conflict winner src", 32'(p_os[2]), 32'd0);

    // R7: first-column loss reported at the offer
    @(negedge clk);
    p_valid = 8'h11; p_dest = '0; p_dest[0] = 3'd5; p_dest[4] = 3'd5;
    #4;
    check("R7", "first-column reject at offer", 32'(p_rej), 32'h10);
    @(negedge clk);
    p_valid = '0;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule